// File: doc/BRIEF.md
# USB Suspend and Remote Wakeup Controller

This block handles the power-management side of a low-speed USB device interface. It watches a bus-activity strobe (any line transition or start-of-frame event) and counts idle time using a free-running tick input, normally one pulse per millisecond. When the bus has been quiet for longer than the suspend threshold, it raises an idle interrupt flag. Firmware then writes the suspend control bit, which the block presents as a halt request to the rest of the chip.

Three events end the suspended state. A resume detected on the bus, a bus reset and an enabled local wake request each clear the halt request and raise their own flag. For remote wakeup, firmware issues a resume-drive request after the bus has been idle long enough. The block then drives resume signaling for a fixed number of ticks and releases it by itself. A bus reset returns the interface state to its reset values, and leaves the rest of the chip alone.

Top module: `usb_susp_ctrl`

## Requirements
- R1: After rst_ni is released, irq_o is 4'b0000, and susp_o and resume_drv_o are 0.
- R2: Flag irq_o[0] (idle) is set after the tick that brings the idle count above IDLE_TICKS (default 3). That is the fourth tick with no activity since the last bus_act_i. It is raised only once per idle period.
- R3: A cycle with bus_act_i high restarts the idle count from zero, even if a tick arrives in the same cycle. No idle flag is raised in that cycle.
- R4: susp_o changes only on a control write (ctl_we_i) or a wake event. A write loads it from ctl_susp_i.
- R5: resume_det_i while susp_o is 1 clears susp_o and sets irq_o[1]. resume_det_i while not suspended has no effect.
- R6: bus_rst_i clears susp_o and resume_drv_o, clears every flag except irq_o[2], sets irq_o[2] and restarts the idle count.
- R7: wake_i while susp_o is 1 and the wake enable (last written ctl_wake_en_i) is 1 clears susp_o and sets irq_o[3]. With the enable at 0, wake_i has no effect.
- R8: A control write with ctl_resume_i=1 and ctl_susp_i=0 starts resume drive only if at least RWU_IDLE_TICKS (default 5) idle ticks have passed. Otherwise the write is ignored.
- R9: Once started, resume_drv_o stays high for exactly RESUME_TICKS ticks (default 20) and then drops by itself. Writes during the drive do not end it early.
- R10: A 1 in irq_clr_i[i] clears irq_o[i]. If a set event for the same flag occurs in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base pulse, one per idle time unit |
| bus_act_i | input | 1 | Bus transition or start-of-frame seen |
| bus_rst_i | input | 1 | Bus reset detected |
| resume_det_i | input | 1 | Resume signaling detected on the bus |
| wake_i | input | 1 | Local wake request |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_susp_i | input | 1 | Suspend bit value for the write |
| ctl_resume_i | input | 1 | Resume-drive request for the write |
| ctl_wake_en_i | input | 1 | Wake enable value for the write |
| irq_clr_i | input | 4 | Write-one-to-clear flag mask |
| irq_o | output | 4 | Flags: [0] idle, [1] bus resume, [2] bus reset, [3] local wake |
| susp_o | output | 1 | Suspend state and halt request |
| resume_drv_o | output | 1 | Resume signaling drive enable |

## Verification
Every output is a register fed directly from the inputs and the held state. Each result is therefore due at the first rising edge after the cycle in which its stimulus is presented. Each driver step presents one cycle of stimulus and then queues the expected outputs for that edge. The monitor compares them at the following falling edge, so no check samples on an active edge. The idle and drive windows are counted in tick pulses, not clock cycles. The bench therefore checks the output after every single tick around each threshold, including the fourth idle tick, the fifth before a drive request, and the twentieth of a drive.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  localparam int unsigned NUM_FLG    = 4;
  localparam int unsigned FLG_IDLE   = 0;
  localparam int unsigned FLG_RESUME = 1;
  localparam int unsigned FLG_BUSRST = 2;
  localparam int unsigned FLG_WAKE   = 3;
endpackage

// File: rtl/usb_susp_idle_tmr.sv
module usb_susp_idle_tmr #(
  parameter int unsigned IDLE_TICKS     = 3,
  parameter int unsigned RWU_IDLE_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic act_i,
  output logic idle_evt_o,
  output logic rwu_ok_o
);
  localparam int unsigned SAT = (IDLE_TICKS + 1 > RWU_IDLE_TICKS) ? IDLE_TICKS + 1 : RWU_IDLE_TICKS;
  localparam int unsigned CW  = $clog2(SAT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (act_i)                       cnt_q <= '0;
    else if (tick_i && cnt_q < CW'(SAT))  cnt_q <= cnt_q + 1'b1;
  end

  // saturation makes the event fire once per idle period
  assign idle_evt_o = tick_i && !act_i && (cnt_q == CW'(IDLE_TICKS));
  assign rwu_ok_o   = (cnt_q >= CW'(RWU_IDLE_TICKS));
endmodule

// File: rtl/usb_susp_resume_drv.sv
module usb_susp_resume_drv #(
  parameter int unsigned RESUME_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic abort_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(RESUME_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && !act_q) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && tick_i) begin
      if (cnt_q == CW'(RESUME_TICKS - 1)) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl
  import usb_susp_pkg::*;
#(
  parameter int unsigned IDLE_TICKS     = 3,
  parameter int unsigned RWU_IDLE_TICKS = 5,
  parameter int unsigned RESUME_TICKS   = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               bus_act_i,
  input  logic               bus_rst_i,
  input  logic               resume_det_i,
  input  logic               wake_i,
  input  logic               ctl_we_i,
  input  logic               ctl_susp_i,
  input  logic               ctl_resume_i,
  input  logic               ctl_wake_en_i,
  input  logic [NUM_FLG-1:0] irq_clr_i,
  output logic [NUM_FLG-1:0] irq_o,
  output logic               susp_o,
  output logic               resume_drv_o
);
  logic               idle_evt, rwu_ok, drv_start, drv_active;
  logic               susp_q, wake_en_q;
  logic [NUM_FLG-1:0] flg_q, flg_set;
  logic               resume_hit, wake_hit;

  usb_susp_idle_tmr #(
    .IDLE_TICKS    (IDLE_TICKS),
    .RWU_IDLE_TICKS(RWU_IDLE_TICKS)
  ) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .act_i     (bus_act_i | bus_rst_i),
    .idle_evt_o(idle_evt),
    .rwu_ok_o  (rwu_ok)
  );

  assign drv_start = ctl_we_i && ctl_resume_i && !ctl_susp_i && rwu_ok;

  usb_susp_resume_drv #(
    .RESUME_TICKS(RESUME_TICKS)
  ) u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .start_i (drv_start),
    .abort_i (bus_rst_i),
    .active_o(drv_active)
  );

  assign resume_hit = resume_det_i && susp_q;
  assign wake_hit   = wake_i && wake_en_q && susp_q;

  always_comb begin
    flg_set             = '0;
    flg_set[FLG_IDLE]   = idle_evt;
    flg_set[FLG_RESUME] = resume_hit;
    flg_set[FLG_BUSRST] = bus_rst_i;
    flg_set[FLG_WAKE]   = wake_hit;
  end

  // suspend state: wake events override a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      susp_q    <= 1'b0;
      wake_en_q <= 1'b0;
    end else if (bus_rst_i) begin
      susp_q    <= 1'b0;
      wake_en_q <= 1'b0;
    end else begin
      if (ctl_we_i) wake_en_q <= ctl_wake_en_i;
      if (resume_hit || wake_hit) susp_q <= 1'b0;
      else if (ctl_we_i)          susp_q <= ctl_susp_i;
    end
  end

  for (genvar g = 0; g < NUM_FLG; g++) begin : g_flg
    localparam logic RST_VAL = (g == FLG_BUSRST);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           flg_q[g] <= 1'b0;
      else if (bus_rst_i)    flg_q[g] <= RST_VAL;
      else if (flg_set[g])   flg_q[g] <= 1'b1;
      else if (irq_clr_i[g]) flg_q[g] <= 1'b0;
    end
  end

  assign irq_o        = flg_q;
  assign susp_o       = susp_q;
  assign resume_drv_o = drv_active;
endmodule

// File: rtl/usb_susp_ctrl_chk.sv
module usb_susp_ctrl_chk
  import usb_susp_pkg::*;
#(
  parameter int unsigned RESUME_TICKS = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               bus_act_i,
  input logic               bus_rst_i,
  input logic               resume_det_i,
  input logic               ctl_we_i,
  input logic               ctl_susp_i,
  input logic               rwu_ok,
  input logic [NUM_FLG-1:0] irq_o,
  input logic               susp_o,
  input logic               resume_drv_o
);
  int unsigned drv_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           drv_ticks <= 0;
    else if (!resume_drv_o) drv_ticks <= 0;
    else if (tick_i)        drv_ticks <= drv_ticks + 1;
  end

  AST_ACT_BLOCKS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act_i |=> !$rose(irq_o[FLG_IDLE])); // R3

  AST_SUSP_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_o) |-> $past(ctl_we_i && ctl_susp_i)); // R4

  AST_RESUME_EXITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o && resume_det_i && !bus_rst_i |=> !susp_o && irq_o[FLG_RESUME]); // R5

  AST_BUS_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !susp_o && !resume_drv_o && irq_o[FLG_BUSRST]); // R6

  AST_DRIVE_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resume_drv_o) |-> $past(rwu_ok)); // R8

  AST_DRIVE_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(resume_drv_o) && !$past(bus_rst_i) |-> $past(tick_i) && ($past(drv_ticks) == RESUME_TICKS - 1)); // R9
endmodule

bind usb_susp_ctrl usb_susp_ctrl_chk #(.RESUME_TICKS(RESUME_TICKS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .bus_act_i   (bus_act_i),
  .bus_rst_i   (bus_rst_i),
  .resume_det_i(resume_det_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_susp_i  (ctl_susp_i),
  .rwu_ok      (rwu_ok),
  .irq_o       (irq_o),
  .susp_o      (susp_o),
  .resume_drv_o(resume_drv_o)
);

// File: tb/test_usb_susp_ctrl.sv
module test_usb_susp_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_ni = 0;
  logic tick = 0, act = 0, brst = 0, rdet = 0, wk = 0;
  logic we = 0, cs = 0, cr = 0, cw = 0;
  logic [3:0] clr = '0;
  logic [3:0] irq;
  logic susp, drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_susp_ctrl i_usb_susp_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .bus_act_i(act), .bus_rst_i(brst),
    .resume_det_i(rdet), .wake_i(wk), .ctl_we_i(we), .ctl_susp_i(cs), .ctl_resume_i(cr),
    .ctl_wake_en_i(cw), .irq_clr_i(clr), .irq_o(irq), .susp_o(susp), .resume_drv_o(drv)
  );

  typedef struct { logic [3:0] irq; logic susp; logic drv; string tag; } exp_t;
  exp_t q[$];
  int compared = 0, mismatched = 0;
  logic [3:0] e_irq = '0;
  logic e_susp = 0, e_drv = 0;
  bit done = 0;

  task automatic push(input string tag);
    exp_t e;
    e.irq = e_irq; e.susp = e_susp; e.drv = e_drv; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input logic t, a, b, r, w, ew, s, rs, en, input logic [3:0] c);
    @(negedge clk);
    tick = t; act = a; brst = b; rdet = r; wk = w; we = ew; cs = s; cr = rs; cw = en; clr = c;
    @(posedge clk);
    #1;
    tick = 0; act = 0; brst = 0; rdet = 0; wk = 0; we = 0; cs = 0; cr = 0; cw = 0; clr = '0;
  endtask

  task automatic do_tick(input string tag);  step(1,0,0,0,0,0,0,0,0,4'h0); push(tag); endtask
  task automatic do_act(input string tag);   step(0,1,0,0,0,0,0,0,0,4'h0); push(tag); endtask
  task automatic do_clr(input logic [3:0] c, input string tag); step(0,0,0,0,0,0,0,0,0,c); push(tag); endtask
  task automatic do_wr(input logic s, rs, en, input string tag); step(0,0,0,0,0,1,s,rs,en,4'h0); push(tag); endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compared++;
        if (irq !== e.irq || susp !== e.susp || drv !== e.drv) begin
          mismatched++;
          $display("FAIL %s: irq=%b exp %b, susp=%b exp %b, drv=%b exp %b",
                   e.tag, irq, e.irq, susp, e.susp, drv, e.drv);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    push("R1 reset state");

    // R2 idle flag on fourth tick, once per period
    do_act("R2 act");
    for (int i = 0; i < 3; i++) do_tick("R2 below threshold");
    e_irq = 4'b0001; do_tick("R2 threshold tick");
    e_irq = 4'b0000; do_clr(4'b0001, "R10 clear idle");
    for (int i = 0; i < 3; i++) do_tick("R2 no second flag");

    // R3 activity restarts count, also with a tick in the same cycle
    do_act("R3 act");
    do_tick("R3 tick1"); do_tick("R3 tick2");
    step(1,1,0,0,0,0,0,0,0,4'h0); push("R3 act with tick");
    for (int i = 0; i < 3; i++) do_tick("R3 restarted count");
    e_irq = 4'b0001; do_tick("R3 flag after restart");
    e_irq = 4'b0000; do_clr(4'b0001, "R10 clear");

    // R4 firmware write controls suspend
    e_susp = 1; do_wr(1,0,0, "R4 set suspend");
    e_susp = 0; do_wr(0,0,0, "R4 clear suspend");
    e_susp = 1; do_wr(1,0,0, "R4 set again");

    // R5 bus resume
    step(0,0,0,1,0,0,0,0,0,4'h0); e_susp = 0; e_irq = 4'b0010; push("R5 resume exits");
    e_irq = 4'b0000; do_clr(4'b0010, "R10 clear resume flag");
    step(0,0,0,1,0,0,0,0,0,4'h0); push("R5 resume while awake ignored");

    // R7 local wake
    e_susp = 1; do_wr(1,0,0, "R7 suspend, wake disabled");
    step(0,0,0,0,1,0,0,0,0,4'h0); push("R7 wake ignored when disabled");
    do_wr(1,0,1, "R7 enable wake");
    step(0,0,0,0,1,0,0,0,0,4'h0); e_susp = 0; e_irq = 4'b1000; push("R7 wake exits");
    e_irq = 4'b0000; do_clr(4'b1000, "R10 clear wake flag");

    // R8 drive needs 5 idle ticks
    do_act("R8 act");
    for (int i = 0; i < 3; i++) do_tick("R8 idle");
    e_irq = 4'b0001; do_tick("R8 idle flag");
    e_irq = 4'b0000; do_clr(4'b0001, "R8 clear");
    do_wr(0,1,1, "R8 request rejected at 4 ticks");
    do_tick("R8 fifth tick");
    e_drv = 1; do_wr(0,1,1, "R8 request accepted");

    // R9 fixed drive length, early clear ignored
    do_wr(0,0,1, "R9 clear write ignored");
    for (int i = 0; i < 19; i++) do_tick("R9 drive held");
    e_drv = 0; do_tick("R9 drive ends at 20");

    // R10 set wins over clear
    do_act("R10 act");
    for (int i = 0; i < 3; i++) do_tick("R10 idle");
    step(1,0,0,0,0,0,0,0,0,4'b0001); e_irq = 4'b0001; push("R10 set beats clear");
    e_irq = 4'b0000; do_clr(4'b0001, "R10 clear");

    // R6 bus reset
    do_tick("R6 fifth tick");
    e_drv = 1; do_wr(0,1,1, "R6 start drive");
    e_susp = 1; do_wr(1,0,1, "R6 suspend during drive");
    step(0,0,1,0,0,0,0,0,0,4'h0); e_susp = 0; e_drv = 0; e_irq = 4'b0100; push("R6 bus reset");
    e_irq = 4'b0000; do_clr(4'b0100, "R6 clear reset flag");
    for (int i = 0; i < 3; i++) do_tick("R6 idle restarted");
    e_irq = 4'b0001; do_tick("R6 idle flag after reset");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule